// File: doc/BRIEF.md
# Three-Channel Square-Wave Tone Generator

This block produces three square-wave tones and mixes them into one weighted digital amplitude word. Software programs it through an 8-bit write-only port: three addresses each set a channel's 6-bit period code, and a fourth address holds two control bits. One of these bits silences the output. The other switches on exclusive-OR (ring) modulation between neighbouring channels.

A single prescaler divides the system clock and issues a tick every `PRESCALE` clocks. Each channel counts these ticks and inverts its square after `63 - P` of them, where `P` is its period code. The code 63 stops the channel at whatever level it holds. The three channel bits are combined with fixed unequal weights, so the three tones have different loudness. The sum is registered and leaves the block together with the registered per-channel bits.

Top module: `tone_trio`

## Requirements
- R1: A write to address 0xF8, 0xF9 or 0xFA loads wr_data_i[5:0] as the period code P of channel 0, 1 or 2. Bits 7:6 of the data are ignored.
- R2: For P below 63, a running channel's square holds each level for exactly PRESCALE*(63-P) clocks. PRESCALE defaults to 512.
- R3: With P equal to 63, the channel's square stops and keeps its present level, including level 1.
- R4: A write to address 0xFB loads the control register. Bit 0 selects XOR mode (1) or normal mode (0). Bit 1 is the audible enable (1 audible, 0 muted). Bits 7:2 are ignored.
- R5: In XOR mode, tone_o[0] carries square0 XOR square1 and tone_o[1] carries square1 XOR square2. tone_o[2] carries square2 unchanged. In normal mode, tone_o[i] carries square i.
- R6: While muted, tone_o and amp_o are 0. Period writes are still accepted and the dividers keep running, so the square phase after unmuting matches the schedule that ran before muting.
- R7: amp_o equals 4*tone_o[0] + 6*tone_o[1] + 8*tone_o[2] in every cycle. Its maximum is 18.
- R8: A register changes only when wr_en_i is 1 and all 8 address bits match its address. Writes to any other address, or with wr_en_i low, have no effect.
- R9: After reset, all period codes are 0, the control register is 0 (muted, normal mode), all counters are 0 and all squares are 0. The first toggle therefore comes 63 ticks after reset release.
- R10: A square changes only on a prescaler tick. A new period code is compared at the following ticks, and the write itself never changes the output level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe for one clock |
| wr_addr_i | input | 8 | I/O write address |
| wr_data_i | input | 8 | I/O write data |
| tone_o | output | 3 | Registered channel bits after modulation and muting |
| amp_o | output | 5 | Registered weighted sum of tone_o |

## Verification
The embedded properties take it for granted that the write strobe, address and data are stable around each rising clock edge. They also assume that reset is held for at least two clocks before any write is expected to take effect, because of the internal release synchronizer. The stimulus changes every input only on falling edges and holds the strobe for exactly one clock. It waits several clocks after reset release before the first write. It runs the bench with a small prescaler, so that the periods can be timed edge to edge in a short run.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int NCH   = 3;
  localparam int PER_W = 6;
  localparam int AMP_W = 5;
  localparam logic [7:0] ADDR_BASE = 8'hF8;
  localparam logic [7:0] ADDR_CTRL = 8'hFB;
  localparam logic [PER_W-1:0] PER_STOP = '1;

  // control register: bit 1 audible, bit 0 xor mode
  typedef struct packed {
    logic aud;
    logic xmod;
  } ctrl_t;

  function automatic int unsigned ch_weight(input int unsigned idx);
    return 4 + 2 * idx;
  endfunction

  function automatic int unsigned amp_max();
    int unsigned s;
    s = 0;
    for (int unsigned i = 0; i < NCH; i++) s += ch_weight(i);
    return s;
  endfunction
endpackage

// File: rtl/tone_prescaler.sv
module tone_prescaler #(
  parameter int unsigned DIV = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(DIV - 1));

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = wrap;
endmodule

// File: rtl/tone_channel.sv
module tone_channel
  import tone_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [PER_W-1:0] wr_data_i,
  output logic             sq_o
);
  logic [PER_W-1:0] per_q, per_d, cnt_q, cnt_d;
  logic [PER_W:0]   limit, cnt_nx;
  logic             sq_q, sq_d;
  logic             per_en, cnt_en, sq_en, frozen, expire;

  always_comb begin
    limit  = {1'b0, PER_STOP} - {1'b0, per_q};
    cnt_nx = {1'b0, cnt_q} + 1'b1;
    frozen = (per_q == PER_STOP);
    expire = tick_i && !frozen && (cnt_nx >= limit);
    per_en = wr_i;
    per_d  = wr_data_i;
    cnt_en = tick_i && !frozen;
    cnt_d  = expire ? '0 : cnt_nx[PER_W-1:0];
    sq_en  = expire;
    sq_d   = ~sq_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      cnt_q <= '0;
      sq_q  <= 1'b0;
    end else begin
      if (per_en) per_q <= per_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (sq_en)  sq_q  <= sq_d;
    end
  end

  assign sq_o = sq_q;

  AST_SQ_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sq_o)) else $error("square moved without tick"); // R10

  AST_FROZEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_q == PER_STOP) |=> $stable(sq_o)) else $error("frozen channel moved"); // R3
endmodule

// File: rtl/tone_mixer.sv
module tone_mixer
  import tone_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NCH-1:0]   sq_i,
  input  ctrl_t            ctrl_i,
  output logic [NCH-1:0]   tone_o,
  output logic [AMP_W-1:0] amp_o
);
  logic [NCH-1:0]   mod, gated, tone_q;
  logic [AMP_W-1:0] amp_d, amp_q;

  for (genvar i = 0; i < NCH; i++) begin : g_mod
    if (i < NCH - 1) begin : g_pair
      assign mod[i] = ctrl_i.xmod ? (sq_i[i] ^ sq_i[i+1]) : sq_i[i];
    end else begin : g_last
      assign mod[i] = sq_i[i];
    end
  end

  always_comb begin
    gated = mod & {NCH{ctrl_i.aud}};
    amp_d = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gated[i]) amp_d = amp_d + AMP_W'(ch_weight(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tone_q <= '0;
      amp_q  <= '0;
    end else begin
      tone_q <= gated;
      amp_q  <= amp_d;
    end
  end

  assign tone_o = tone_q;
  assign amp_o  = amp_q;

  AST_MUTE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.aud |=> (amp_o == '0 && tone_o == '0)) else $error("sound while muted"); // R6

  AST_LAST_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.aud |=> (tone_o[NCH-1] == $past(sq_i[NCH-1]))) else $error("last channel altered"); // R5

  AST_AMP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(amp_o) <= amp_max()) else $error("amplitude out of range"); // R7
endmodule

// File: rtl/tone_trio.sv
module tone_trio
  import tone_pkg::*;
#(
  parameter int unsigned PRESCALE = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  output logic [NCH-1:0]   tone_o,
  output logic [AMP_W-1:0] amp_o
);
  logic [1:0]     rsync_q;
  logic           rst_int_n;
  logic           tick;
  logic [NCH-1:0] sq;
  logic           ctrl_hit;
  ctrl_t          ctrl_q, ctrl_d;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  tone_prescaler #(.DIV(PRESCALE)) presc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .tick_o (tick)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = wr_en_i && (wr_addr_i == ADDR_BASE + 8'(i));
    tone_channel ch_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_int_n),
      .tick_i    (tick),
      .wr_i      (hit),
      .wr_data_i (wr_data_i[PER_W-1:0]),
      .sq_o      (sq[i])
    );
  end

  always_comb begin
    ctrl_hit = wr_en_i && (wr_addr_i == ADDR_CTRL);
    ctrl_d   = ctrl_t'(wr_data_i[1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n)    ctrl_q <= '0;
    else if (ctrl_hit) ctrl_q <= ctrl_d;
  end

  tone_mixer mix_i (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .sq_i   (sq),
    .ctrl_i (ctrl_q),
    .tone_o (tone_o),
    .amp_o  (amp_o)
  );

  AST_CTRL_DECODE: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    !(wr_en_i && wr_addr_i == ADDR_CTRL) |=> $stable(ctrl_q)) else $error("control changed without write"); // R8
endmodule

// File: tb/tone_trio_tb_top.sv
`timescale 1ns/1ps
module tone_trio_tb_top;
  localparam int unsigned PRE = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data;
  logic [2:0] tone;
  logic [4:0] amp;
  int cyc = 0;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tone_trio #(.PRESCALE(PRE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .tone_o(tone), .amp_o(amp)
  );

  // address, data, expected ticks per half period
  localparam logic [21:0] VEC [6] = '{
    {8'hF8, 8'h3E, 6'd1},
    {8'hF8, 8'hFD, 6'd2},
    {8'hF9, 8'h3C, 6'd3},
    {8'hFA, 8'h7B, 6'd4},
    {8'hF8, 8'h00, 6'd63},
    {8'hFA, 8'hC0, 6'd63}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic wait_edge(input int ch, output int t);
    logic prev;
    int   lim;
    prev = tone[ch];
    lim  = cyc + 3000;
    do @(negedge clk); while (tone[ch] == prev && cyc < lim);
    t = cyc;
  endtask

  task automatic measure(input int ch, output int half);
    int t1, t2, t3;
    wait_edge(ch, t1);
    wait_edge(ch, t2);
    wait_edge(ch, t3);
    half = t3 - t2;
  endtask

  task automatic amp_scan(input int n, input string req);
    int bad, got, exp;
    bad = 0; got = 0; exp = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (int'(amp) != 4 * tone[0] + 6 * tone[1] + 8 * tone[2]) begin
        bad++; got = amp; exp = 4 * tone[0] + 6 * tone[1] + 8 * tone[2];
      end
    end
    check(bad == 0, req, got, exp);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int half, ch, e, t, bad, tog;
    logic [2:0] last;
    do_reset();
    // R9: reset state, then audible with P=0: nothing before 63 ticks
    check(tone == 3'b000 && amp == 5'd0, "R9 reset outputs", {amp, tone}, 0);
    wr(8'hFB, 8'h02);
    bad = 0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (tone != 3'b000) bad++;
    end
    check(bad == 0, "R9 no toggle before 63 ticks", bad, 0);

    // R1 R2: table of period writes
    for (int v = 0; v < 6; v++) begin
      ch = int'(VEC[v][21:14]) - 8'hF8;
      wr(VEC[v][21:14], VEC[v][13:6]);
      measure(ch, half);
      check(half == int'(PRE) * int'(VEC[v][5:0]), "R1 R2 half period", half, int'(PRE) * int'(VEC[v][5:0]));
    end
    amp_scan(300, "R7 weighted sum");

    // R8: stray writes do not disturb channel 0
    wr(8'hF8, 8'h3E);
    wr(8'h78, 8'h00);
    wr(8'hFC, 8'h00);
    wr(8'hF7, 8'h00);
    @(negedge clk); wr_addr = 8'hF8; wr_data = 8'h00;
    @(negedge clk);
    measure(0, half);
    check(half == int'(PRE), "R8 decode", half, PRE);
    wr(8'hFB, 8'hFE); // R4: upper bits ignored, stays audible normal
    measure(0, half);
    check(half == int'(PRE), "R4 control upper bits", half, PRE);

    // R6: mute keeps dividers running
    wait_edge(0, e);
    wr(8'hFB, 8'h00);
    bad = 0;
    for (int k = 0; k < 43; k++) begin
      @(negedge clk);
      if (k > 2 && (tone != 3'b000 || amp != 5'd0)) bad++;
    end
    check(bad == 0, "R6 muted silent", bad, 0);
    wr(8'hF9, 8'h3D); // accepted while muted
    wr(8'hFB, 8'h02);
    repeat (3) @(negedge clk);
    wait_edge(0, t);
    check((t - e) % int'(PRE) == 0, "R6 phase continues", (t - e) % int'(PRE), 0);
    measure(1, half);
    check(half == 2 * int'(PRE), "R6 write while muted", half, 2 * PRE);

    // R3 R5 R10: freeze channel 1 high, run channel 2
    do_reset();
    wr(8'hF8, 8'hFF);
    wr(8'hFB, 8'h02);
    wr(8'hFA, 8'h3E);
    wr(8'hF9, 8'h3E);
    do @(negedge clk); while (tone[1] != 1'b1);
    wr(8'hF9, 8'hFF);
    repeat (20) @(negedge clk);
    bad = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (tone[1] != 1'b1 || tone[0] != 1'b0) bad++;
    end
    check(bad == 0, "R3 frozen at one", bad, 0);
    measure(2, half);
    check(half == int'(PRE), "R10 running neighbour", half, PRE);
    wr(8'hFB, 8'h03);
    repeat (3) @(negedge clk);
    bad = 0; tog = 0; last = tone;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (tone[0] != 1'b1) bad++;
      if (tone[1] != ~tone[2]) bad++;
      if (tone[2] != last[2]) tog++;
      last = tone;
    end
    check(bad == 0, "R5 xor mapping", bad, 0);
    check(tog >= 8, "R5 last channel passes", tog, 10);
    amp_scan(80, "R7 weighted sum in xor");
    wr(8'hFB, 8'h02);
    repeat (3) @(negedge clk);
    check(tone[1:0] == 2'b10, "R4 back to normal", tone[1:0], 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule